// File: doc/BRIEF.md
# Vector Mask and Compress Unit

This block adds conditional execution to a small vector register file. It can build a mask from a signed comparison against zero and complement a mask. It can load a vector register with every element or only under a mask, and it can stream a register out either whole or compressed. A compressed stream packs the elements whose mask bit is set to the front of the result.

A command is a single cycle on the command port. It carries an opcode, a vector register select, a source and a destination mask select, and a vector length. The unit then works through one element per cycle and holds `busy` high until the last element is done. Load data enters one element per clock on `din`. Store and compress results leave one element per clock on `dout`, marked by `dout_valid`. Elements are 16-bit signed. There are two vector registers and two mask registers, and each mask has one bit per element of the 8-element vector.

Top module: `vmc_unit`

## Requirements
- R1: After reset, `busy`, `dout_valid`, `dout` and `pack_count` are zero, and every element of both vector registers and every bit of both mask registers is zero.
- R2: A command is accepted on a clock edge where `cmd_valid` is 1, `busy` is 0, `cmd_op` is one of the legal codes (0 load, 1 masked load, 2 store, 3 compress, 4 set mask if greater than zero, 5 mask invert) and `cmd_vl` is nonzero. A length above 8 is treated as 8. After acceptance `busy` stays high for exactly that many cycles. Codes 6 and 7, a zero length, and any command presented while `busy` is high are ignored.
- R3: For load (code 0), the k-th `din` value is sampled on the (k+1)-th rising edge after the accepting edge and is written to element k of the selected register, for k below the length.
- R4: For masked load (code 1), element k of the selected register is written only when bit k of the source mask is 1. All other elements keep their previous values.
- R5: For set mask if greater than zero (code 4), bit i of the destination mask becomes 1 exactly when element i of the selected register is strictly positive as a signed value, for i below the length. Bits at or above the length are unchanged.
- R6: For mask invert (code 5), bit i of the destination mask becomes the complement of bit i of the source mask for i below the length. Bits at or above the length are unchanged.
- R7: For store (code 2), `dout` carries element k of the selected register with `dout_valid` high in the k-th cycle after acceptance, for k below the length, regardless of any mask.
- R8: For compress (code 3), the output stream holds, in ascending index order, the elements whose source mask bit is 1 among the first length elements. Stream positions at or beyond that count are zero.
- R9: On acceptance of a compress, `pack_count` becomes the number of set source mask bits among the first length bits. It holds that value until the next compress is accepted.
- R10: `dout_valid` is high only while a store or a compress is in progress. When `dout_valid` is low, `dout` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Operation code |
| cmd_vreg | input | 1 | Vector register select (source or destination) |
| cmd_msrc | input | 1 | Source mask select |
| cmd_mdst | input | 1 | Destination mask select |
| cmd_vl | input | 4 | Vector length, 1 to 8, larger values clamped |
| din | input | 16 | Element-serial load data |
| busy | output | 1 | Command in progress |
| dout | output | 16 | Element-serial store or compress data |
| dout_valid | output | 1 | `dout` holds a result element |
| pack_count | output | 4 | Element count of the last compress |

## Verification
On every cycle the assertions check these properties: `busy` advances one element per cycle and drops right after the last element, no command is taken while busy, `dout` is zero whenever it is not valid, the zero tail of a compress stream, and the rule that `pack_count` moves only on an accepted command. Only the bench scenarios can show the data results. These include the masks that the positive test and the inversion produce, the elements that a masked load preserves, the order of a compressed stream, and the fact that ignored commands leave the registers untouched. The bench sweeps all 256 mask patterns at varying lengths against a model of its own.

// File: rtl/vmc_pkg.sv
package vmc_pkg;
    localparam int ELEM_W = 16;
    localparam int VLEN   = 8;
    localparam int NVREG  = 2;
    localparam int NMREG  = 2;
    localparam int IDX_W  = (VLEN > 1) ? $clog2(VLEN) : 1;
    localparam int CNT_W  = $clog2(VLEN + 1);
    localparam int VSEL_W = (NVREG > 1) ? $clog2(NVREG) : 1;
    localparam int MSEL_W = (NMREG > 1) ? $clog2(NMREG) : 1;

    typedef logic signed [ELEM_W-1:0] elem_t;
    typedef elem_t [VLEN-1:0]         vec_t;
    typedef logic [VLEN-1:0]          mask_t;

    typedef enum logic [2:0] {
        OP_LD   = 3'd0,
        OP_LDM  = 3'd1,
        OP_ST   = 3'd2,
        OP_CMP  = 3'd3,
        OP_GTZ  = 3'd4,
        OP_MNOT = 3'd5
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [VSEL_W-1:0] vsel;
        logic [MSEL_W-1:0] msrc;
        logic [MSEL_W-1:0] mdst;
        logic [CNT_W-1:0]  vl;
    } cmd_t;

    function automatic logic op_legal(input logic [2:0] code);
        return code <= 3'd5;
    endfunction

    function automatic mask_t lane_mask(input logic [CNT_W-1:0] vl);
        mask_t m;
        for (int i = 0; i < VLEN; i++) m[i] = (CNT_W'(i) < vl);
        return m;
    endfunction

    function automatic logic [CNT_W-1:0] popcount(input mask_t m);
        logic [CNT_W-1:0] s;
        s = '0;
        for (int i = 0; i < VLEN; i++) s = s + CNT_W'(m[i]);
        return s;
    endfunction

    function automatic vec_t compress(input vec_t v, input mask_t m);
        vec_t             r;
        logic [IDX_W-1:0] p;
        r = '0;
        p = '0;
        for (int i = 0; i < VLEN; i++) begin
            if (m[i]) begin
                r[p] = v[i];
                p    = p + 1'b1;
            end
        end
        return r;
    endfunction

    function automatic logic is_positive(input elem_t e);
        return (e > 0);
    endfunction
endpackage

// File: rtl/vmc_vreg_file.sv
module vmc_vreg_file
    import vmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [VSEL_W-1:0] wsel,
    input  logic [IDX_W-1:0]  widx,
    input  elem_t             wdata,
    output vec_t              rd [NVREG]
);
    vec_t regs [NVREG];

    for (genvar g = 0; g < NVREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (we && wsel == VSEL_W'(g)) begin
                regs[g][widx] <= wdata;
            end
        end
        assign rd[g] = regs[g];
    end
endmodule

// File: rtl/vmc_mask_file.sv
module vmc_mask_file
    import vmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [MSEL_W-1:0] wsel,
    input  logic [IDX_W-1:0]  widx,
    input  logic              wbit,
    output mask_t             rd [NMREG]
);
    mask_t regs [NMREG];

    for (genvar g = 0; g < NMREG; g++) begin : g_mask
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (we && wsel == MSEL_W'(g)) begin
                regs[g][widx] <= wbit;
            end
        end
        assign rd[g] = regs[g];
    end
endmodule

// File: rtl/vmc_seq.sv
module vmc_seq
    import vmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [VSEL_W-1:0] cmd_vreg,
    input  logic [MSEL_W-1:0] cmd_msrc,
    input  logic [MSEL_W-1:0] cmd_mdst,
    input  logic [CNT_W-1:0]  cmd_vl,
    input  elem_t             din,
    input  vec_t              vregs [NVREG],
    input  mask_t             masks [NMREG],
    output logic              v_we,
    output logic [VSEL_W-1:0] v_wsel,
    output logic [IDX_W-1:0]  v_widx,
    output elem_t             v_wdata,
    output logic              m_we,
    output logic [MSEL_W-1:0] m_wsel,
    output logic [IDX_W-1:0]  m_widx,
    output logic              m_wbit,
    output logic              busy,
    output elem_t             dout,
    output logic              dout_valid,
    output logic [CNT_W-1:0]  pack_count,
    output logic              accept,
    output logic [IDX_W-1:0]  idx,
    output logic [CNT_W-1:0]  cur_vl,
    output logic [2:0]        cur_op
);
    logic             busy_q;
    logic [IDX_W-1:0] idx_q;
    cmd_t             cur_q;
    logic [CNT_W-1:0] pack_q;
    logic [CNT_W-1:0] vl_eff;
    logic             last;

    vec_t  src_vec;
    elem_t src_elem;
    mask_t src_mask;
    vec_t  packed_vec;

    assign vl_eff = (cmd_vl > CNT_W'(VLEN)) ? CNT_W'(VLEN) : cmd_vl;
    assign accept = cmd_valid && !busy_q && op_legal(cmd_op) && (cmd_vl != '0);
    assign last   = (CNT_W'(idx_q) == cur_q.vl - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            cur_q  <= '0;
            pack_q <= '0;
        end else if (accept) begin
            busy_q     <= 1'b1;
            idx_q      <= '0;
            cur_q.op   <= op_e'(cmd_op);
            cur_q.vsel <= cmd_vreg;
            cur_q.msrc <= cmd_msrc;
            cur_q.mdst <= cmd_mdst;
            cur_q.vl   <= vl_eff;
            if (op_e'(cmd_op) == OP_CMP) begin
                pack_q <= popcount(masks[cmd_msrc] & lane_mask(vl_eff));
            end
        end else if (busy_q) begin
            if (last) begin
                busy_q <= 1'b0;
                idx_q  <= '0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign src_vec    = vregs[cur_q.vsel];
    assign src_elem   = src_vec[idx_q];
    assign src_mask   = masks[cur_q.msrc];
    assign packed_vec = compress(src_vec, src_mask & lane_mask(cur_q.vl));

    always_comb begin
        v_we       = 1'b0;
        m_we       = 1'b0;
        m_wbit     = 1'b0;
        dout       = '0;
        dout_valid = 1'b0;
        if (busy_q) begin
            unique case (cur_q.op)
                OP_LD:   v_we = 1'b1;
                OP_LDM:  v_we = src_mask[idx_q];
                OP_GTZ: begin
                    m_we   = 1'b1;
                    m_wbit = is_positive(src_elem);
                end
                OP_MNOT: begin
                    m_we   = 1'b1;
                    m_wbit = ~src_mask[idx_q];
                end
                OP_ST: begin
                    dout       = src_elem;
                    dout_valid = 1'b1;
                end
                OP_CMP: begin
                    dout       = packed_vec[idx_q];
                    dout_valid = 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign v_wsel     = cur_q.vsel;
    assign v_widx     = idx_q;
    assign v_wdata    = din;
    assign m_wsel     = cur_q.mdst;
    assign m_widx     = idx_q;
    assign busy       = busy_q;
    assign pack_count = pack_q;
    assign idx        = idx_q;
    assign cur_vl     = cur_q.vl;
    assign cur_op     = cur_q.op;
endmodule

// File: rtl/vmc_unit.sv
module vmc_unit
    import vmc_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cmd_valid,
    input  logic [2:0]              cmd_op,
    input  logic [VSEL_W-1:0]       cmd_vreg,
    input  logic [MSEL_W-1:0]       cmd_msrc,
    input  logic [MSEL_W-1:0]       cmd_mdst,
    input  logic [CNT_W-1:0]        cmd_vl,
    input  logic [ELEM_W-1:0]       din,
    output logic                    busy,
    output logic [ELEM_W-1:0]       dout,
    output logic                    dout_valid,
    output logic [CNT_W-1:0]        pack_count
);
    vec_t              vregs [NVREG];
    mask_t             masks [NMREG];
    logic              v_we, m_we, m_wbit;
    logic [VSEL_W-1:0] v_wsel;
    logic [MSEL_W-1:0] m_wsel;
    logic [IDX_W-1:0]  v_widx, m_widx;
    elem_t             v_wdata;
    elem_t             dout_e;
    logic              accept;
    logic [IDX_W-1:0]  idx;
    logic [CNT_W-1:0]  cur_vl;
    logic [2:0]        cur_op;

    vmc_vreg_file u_vrf (
        .clk(clk), .rst(rst), .we(v_we), .wsel(v_wsel), .widx(v_widx),
        .wdata(v_wdata), .rd(vregs)
    );

    vmc_mask_file u_mrf (
        .clk(clk), .rst(rst), .we(m_we), .wsel(m_wsel), .widx(m_widx),
        .wbit(m_wbit), .rd(masks)
    );

    vmc_seq u_seq (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_vreg(cmd_vreg), .cmd_msrc(cmd_msrc), .cmd_mdst(cmd_mdst),
        .cmd_vl(cmd_vl), .din(elem_t'(din)), .vregs(vregs), .masks(masks),
        .v_we(v_we), .v_wsel(v_wsel), .v_widx(v_widx), .v_wdata(v_wdata),
        .m_we(m_we), .m_wsel(m_wsel), .m_widx(m_widx), .m_wbit(m_wbit),
        .busy(busy), .dout(dout_e), .dout_valid(dout_valid),
        .pack_count(pack_count), .accept(accept), .idx(idx),
        .cur_vl(cur_vl), .cur_op(cur_op)
    );

    assign dout = dout_e;
endmodule

// File: rtl/vmc_unit_chk.sv
module vmc_unit_chk
    import vmc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              dout_valid,
    input logic [ELEM_W-1:0] dout,
    input logic [CNT_W-1:0]  pack_count,
    input logic              accept,
    input logic [IDX_W-1:0]  idx,
    input logic [CNT_W-1:0]  cur_vl,
    input logic [2:0]        cur_op
);
    a_r2_no_accept_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !accept);

    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        (busy && CNT_W'(idx) != cur_vl - 1'b1) |=> (busy && idx == $past(idx) + 1'b1));

    a_r2_end: assert property (@(posedge clk) disable iff (rst)
        (busy && CNT_W'(idx) == cur_vl - 1'b1) |=> !busy);

    a_r10_valid_busy: assert property (@(posedge clk) disable iff (rst)
        dout_valid |-> (busy && (cur_op == 3'd2 || cur_op == 3'd3)));

    a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !dout_valid |-> dout == '0);

    a_r9_count_range: assert property (@(posedge clk) disable iff (rst)
        pack_count <= CNT_W'(VLEN));

    a_r9_count_moves_on_accept: assert property (@(posedge clk) disable iff (rst)
        !$stable(pack_count) |-> $past(accept));

    a_r8_tail_zero: assert property (@(posedge clk) disable iff (rst)
        (dout_valid && cur_op == 3'd3 && CNT_W'(idx) >= pack_count) |-> dout == '0);
endmodule

bind vmc_unit vmc_unit_chk u_chk (
    .clk(clk), .rst(rst), .busy(busy), .dout_valid(dout_valid), .dout(dout),
    .pack_count(pack_count), .accept(accept), .idx(idx), .cur_vl(cur_vl),
    .cur_op(cur_op)
);

// File: tb/vmc_unit_bench.sv
`timescale 1ns/1ps
module vmc_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [0:0]  cmd_vreg = '0, cmd_msrc = '0, cmd_mdst = '0;
    logic [3:0]  cmd_vl = '0;
    logic [15:0] din = '0;
    logic        busy, dout_valid;
    logic [15:0] dout;
    logic [3:0]  pack_count;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic signed [15:0] vm [2][8];
    logic [7:0]         mm [2];
    logic signed [15:0] zd [8];
    logic signed [15:0] dd [8];

    always #5 clk = ~clk;

    vmc_unit u_vmc_unit (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_vreg(cmd_vreg), .cmd_msrc(cmd_msrc), .cmd_mdst(cmd_mdst),
        .cmd_vl(cmd_vl), .din(din), .busy(busy), .dout(dout),
        .dout_valid(dout_valid), .pack_count(pack_count)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run(input int op, input int v, input int ms, input int md,
                       input int vlin, input logic signed [15:0] d [8],
                       input bit inject);
        int n;
        int cnt;
        bit legal;
        logic signed [15:0] ex [8];
        logic [7:0] src;
        n     = (vlin > 8) ? 8 : vlin;
        legal = (op <= 5) && (vlin != 0);
        cnt   = 0;
        for (int i = 0; i < 8; i++) ex[i] = '0;
        if (op == 2) for (int i = 0; i < n; i++) ex[i] = vm[v][i];
        if (op == 3) begin
            for (int i = 0; i < n; i++) if (mm[ms][i]) begin ex[cnt] = vm[v][i]; cnt++; end
        end
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'(op); cmd_vreg = 1'(v);
        cmd_msrc = 1'(ms); cmd_mdst = 1'(md); cmd_vl = 4'(vlin);
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        if (!legal) begin
            chk(busy == 1'b0, "R2 ignored command", int'(busy), 0);
            return;
        end
        for (int k = 0; k < n; k++) begin
            din = d[k];
            if (inject && k == 1) begin
                cmd_valid = 1'b1; cmd_op = 3'd5; cmd_msrc = 1'b0;
                cmd_mdst = 1'b0; cmd_vl = 4'd8;
            end
            chk(busy == 1'b1, "R2 busy during command", int'(busy), 1);
            if (op == 3 && k == 0)
                chk(pack_count == 4'(cnt), "R9 pack count", int'(pack_count), cnt);
            if (op == 2 || op == 3) begin
                chk(dout_valid == 1'b1, "R7 R8 output valid", int'(dout_valid), 1);
                chk(dout == ex[k], op == 2 ? "R7 store element" : "R8 compress element",
                    int'($signed(dout)), int'(ex[k]));
            end else begin
                chk(dout_valid == 1'b0, "R10 no output for non-output op", int'(dout_valid), 0);
            end
            @(posedge clk);
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        chk(busy == 1'b0, "R2 busy ends after length", int'(busy), 0);
        chk(dout_valid == 1'b0 && dout == 16'd0, "R10 idle output zero", int'(dout), 0);
        if (op == 3) chk(pack_count == 4'(cnt), "R9 count held", int'(pack_count), cnt);
        src = mm[ms];
        for (int k = 0; k < n; k++) begin
            case (op)
                0: vm[v][k] = d[k];
                1: if (mm[ms][k]) vm[v][k] = d[k];
                4: mm[md][k] = (vm[v][k] > 0);
                5: mm[md][k] = ~src[k];
                default: ;
            endcase
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) zd[i] = '0;
        for (int r = 0; r < 2; r++) begin
            mm[r] = '0;
            for (int i = 0; i < 8; i++) vm[r][i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state at the ports
        chk(busy == 0, "R1 busy after reset", int'(busy), 0);
        chk(dout_valid == 0, "R1 dout_valid after reset", int'(dout_valid), 0);
        chk(pack_count == 0, "R1 pack_count after reset", int'(pack_count), 0);
        // R1 registers read back as zero
        run(2, 0, 0, 0, 8, zd, 0);
        run(2, 1, 0, 0, 8, zd, 0);
        run(3, 0, 1, 0, 8, zd, 0);
        run(3, 1, 0, 0, 8, zd, 0);

        // R3 load with clamp of length 12 to 8 (R2)
        for (int i = 0; i < 8; i++) dd[i] = 16'(11 * (i + 1));
        run(0, 0, 0, 0, 12, dd, 0);
        run(2, 0, 0, 0, 8, zd, 0);
        // R2 zero length and illegal codes ignored
        run(0, 0, 0, 0, 0, dd, 0);
        run(6, 0, 0, 0, 8, dd, 0);
        run(7, 1, 1, 1, 3, dd, 0);
        run(2, 0, 0, 0, 8, zd, 0);
        run(3, 0, 0, 0, 8, zd, 0);

        // main sweep over all mask patterns (R4 R5 R6 R8 R9)
        for (int pat = 0; pat < 256; pat++) begin
            int vl;
            vl = (pat % 8) + 1;
            for (int i = 0; i < 8; i++) begin
                if (pat[i]) dd[i] = (i == 0) ? 16'sd1 : (i == 7) ? 16'sd32767 : 16'(50 * i + 3);
                else        dd[i] = (i % 2 == 1) ? 16'sd0 : 16'(-32768 + 100 * i);
            end
            run(0, 1, 0, 0, 8, dd, 0);
            run(4, 1, 0, 0, vl, zd, 0);
            run(3, 0, 0, 0, 8, zd, 0);
            run(5, 0, 0, 1, 8 - (pat % 3), zd, 0);
            run(3, 0, 1, 0, 8, zd, 0);
            run(3, 1, 1, 0, vl, zd, 0);
            if (pat % 16 == 5) begin
                for (int i = 0; i < 8; i++) dd[i] = 16'(pat * 7 + i - 900);
                run(1, 0, 0, 0, vl, dd, 0);
                run(2, 0, 1, 0, 8, zd, 0);
                run(1, 1, 1, 0, 8, dd, 0);
                run(2, 1, 0, 0, 8, zd, 0);
            end
        end

        // R2 command presented while busy is ignored: m0 must keep its bits
        run(2, 0, 0, 0, 8, zd, 1);
        run(3, 0, 0, 0, 8, zd, 0);
        run(3, 1, 0, 0, 8, zd, 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule